// File: doc/BRIEF.md
# Supply Lockout and Shutdown Controller

This block watches a digitised supply-voltage code and three synchronous control inputs: sleep, enable and auxiliary enable. From them it produces the enables for the rest of a PWM controller. A hysteretic comparison against two programmable thresholds decides whether the supply is valid. A run of consecutive samples is needed before that decision changes, so single noisy samples do not toggle it.

The supply decision is combined with the control inputs through a fixed priority. Sleep shuts everything off. Undervoltage stops the switching and error paths. A low enable stops only the switching path. The auxiliary amplifier enable follows its own input unless sleep is asserted. A soft-start discharge command is raised whenever switching must be held at zero duty. Every output is registered.

Top module: `supv_ctrl`

## Requirements
- R1: While rst_ni is low, pgood_o, ref_en_o, err_en_o, run_en_o and aux_en_o are 0 and soft_dis_o is 1. The internal supply state is "locked out".
- R2: From the locked-out state, the supply becomes valid after FILT_LEN consecutive clock samples in which supply_i >= the rising threshold (unsigned compare, equality counts). The rising threshold is th_rise_i registered one clock earlier.
- R3: From the valid state, the supply becomes locked out after FILT_LEN consecutive samples in which supply_i is strictly below the falling threshold. The falling threshold is th_fall_i registered one clock earlier.
- R4: A qualifying run shorter than FILT_LEN, or any sample that does not qualify, including a sample in the band between the thresholds, leaves the supply state unchanged and restarts the count.
- R5: While locked out, run_en_o, err_en_o and pgood_o are 0 and soft_dis_o is 1.
- R6: When sleep_i is 1, the next outputs are pgood_o, ref_en_o, err_en_o, run_en_o and aux_en_o = 0 and soft_dis_o = 1, whatever en_i and aux_en_i are.
- R7: With sleep_i at 0 and en_i at 0, run_en_o is 0, while ref_en_o is 1 and err_en_o and pgood_o follow the supply state.
- R8: With sleep_i at 0, aux_en_o equals aux_en_i one clock earlier, independently of en_i and of the supply state.
- R9: soft_dis_o is 1 exactly when en_i was 0, sleep_i was 1, or the supply state was locked out at the previous clock edge.
- R10: All outputs are registered. An output reflects the inputs and the supply state present at the preceding rising clock edge. A supply state change therefore appears on the outputs one clock after the edge at which it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_i | input | W | Unsigned supply sample |
| th_rise_i | input | W | Threshold for the supply to become valid |
| th_fall_i | input | W | Threshold below which the supply is locked out |
| sleep_i | input | 1 | Full shutdown, active high |
| en_i | input | 1 | Oscillator and output drive enable, active high |
| aux_en_i | input | 1 | Auxiliary amplifier enable, active high |
| pgood_o | output | 1 | Supply valid flag |
| ref_en_o | output | 1 | Reference and bias enable |
| err_en_o | output | 1 | Error amplifier and comparator enable |
| run_en_o | output | 1 | Oscillator and output drive enable |
| aux_en_o | output | 1 | Auxiliary amplifier enable |
| soft_dis_o | output | 1 | Soft-start node discharge command |

## Verification
The bench builds the block with W = 8 and FILT_LEN = 3. A three-sample filter keeps whole rising and falling runs, and runs cut one sample short, within a few dozen cycles. Thresholds of 200 and 170 in an 8-bit range leave room to drive samples exactly at each threshold, one code beyond it and inside the hysteresis band. This exercises both the inclusive rising compare and the strict falling compare. The sleep, enable and auxiliary inputs are stepped through their combinations in both supply states.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef struct packed {
    logic pgood;
    logic ref_en;
    logic err_en;
    logic run_en;
    logic aux_en;
    logic soft_dis;
  } supv_en_t;

  localparam supv_en_t SUPV_EN_RST = '{pgood: 1'b0, ref_en: 1'b0, err_en: 1'b0,
                                       run_en: 1'b0, aux_en: 1'b0, soft_dis: 1'b1};
endpackage

// File: rtl/supv_thr_reg.sv
module supv_thr_reg #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] th_rise_i,
  input  logic [W-1:0] th_fall_i,
  output logic [W-1:0] th_rise_o,
  output logic [W-1:0] th_fall_o
);
  // reset values keep the lockout state where it is until real thresholds land
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      th_rise_o <= '1;
      th_fall_o <= '0;
    end else begin
      th_rise_o <= th_rise_i;
      th_fall_o <= th_fall_i;
    end
  end
endmodule

// File: rtl/supv_lockout.sv
module supv_lockout #(
  parameter int W        = 10,
  parameter int FILT_LEN = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] supply_i,
  input  logic [W-1:0] th_rise_i,
  input  logic [W-1:0] th_fall_i,
  output logic         ok_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          ok_q;
  logic          qual;

  assign qual = ok_q ? (supply_i < th_fall_i) : (supply_i >= th_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!qual) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      ok_q  <= ~ok_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/supv_gate.sv
module supv_gate (
  input  logic               ok_i,
  input  logic               sleep_i,
  input  logic               en_i,
  input  logic               aux_en_i,
  output supv_pkg::supv_en_t en_o
);
  always_comb begin
    en_o.ref_en   = ~sleep_i;
    en_o.pgood    = ok_i & ~sleep_i;
    en_o.err_en   = ok_i & ~sleep_i;
    en_o.run_en   = ok_i & ~sleep_i & en_i;
    en_o.aux_en   = aux_en_i & ~sleep_i;
    en_o.soft_dis = sleep_i | ~en_i | ~ok_i;
  end
endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl #(
  parameter int W        = 10,
  parameter int FILT_LEN = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] supply_i,
  input  logic [W-1:0] th_rise_i,
  input  logic [W-1:0] th_fall_i,
  input  logic         sleep_i,
  input  logic         en_i,
  input  logic         aux_en_i,
  output logic         pgood_o,
  output logic         ref_en_o,
  output logic         err_en_o,
  output logic         run_en_o,
  output logic         aux_en_o,
  output logic         soft_dis_o
);
  logic [W-1:0]       th_rise_q, th_fall_q;
  logic               ok;
  supv_pkg::supv_en_t en_d, en_q;

  supv_thr_reg #(.W(W)) u_thr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .th_rise_i (th_rise_i),
    .th_fall_i (th_fall_i),
    .th_rise_o (th_rise_q),
    .th_fall_o (th_fall_q)
  );

  supv_lockout #(.W(W), .FILT_LEN(FILT_LEN)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .supply_i  (supply_i),
    .th_rise_i (th_rise_q),
    .th_fall_i (th_fall_q),
    .ok_o      (ok)
  );

  supv_gate u_gate (
    .ok_i     (ok),
    .sleep_i  (sleep_i),
    .en_i     (en_i),
    .aux_en_i (aux_en_i),
    .en_o     (en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= supv_pkg::SUPV_EN_RST;
    else         en_q <= en_d;
  end

  assign pgood_o    = en_q.pgood;
  assign ref_en_o   = en_q.ref_en;
  assign err_en_o   = en_q.err_en;
  assign run_en_o   = en_q.run_en;
  assign aux_en_o   = en_q.aux_en;
  assign soft_dis_o = en_q.soft_dis;
endmodule

// File: rtl/supv_ctrl_chk.sv
module supv_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_i,
  input logic en_i,
  input logic aux_en_i,
  input logic pgood_o,
  input logic ref_en_o,
  input logic err_en_o,
  input logic run_en_o,
  input logic aux_en_o,
  input logic soft_dis_o
);
  p_sleep_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!pgood_o && !ref_en_o && !err_en_o && !run_en_o && !aux_en_o && soft_dis_o));

  p_run_needs_good_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_o |-> (pgood_o && err_en_o));

  p_en_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !sleep_i) |=> (!run_en_o && ref_en_o && soft_dis_o));

  p_aux_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |=> (aux_en_o == $past(aux_en_i)));

  p_soft_vs_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_o |-> !soft_dis_o);

  p_good_vs_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o == err_en_o);
endmodule

bind supv_ctrl supv_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sleep_i    (sleep_i),
  .en_i       (en_i),
  .aux_en_i   (aux_en_i),
  .pgood_o    (pgood_o),
  .ref_en_o   (ref_en_o),
  .err_en_o   (err_en_o),
  .run_en_o   (run_en_o),
  .aux_en_o   (aux_en_o),
  .soft_dis_o (soft_dis_o)
);

// File: tb/sim_supv_ctrl.sv
`timescale 1ns/1ps
module sim_supv_ctrl;
  localparam int W        = 8;
  localparam int FILT_LEN = 3;
  localparam logic [W-1:0] TH_RISE = 8'd200;
  localparam logic [W-1:0] TH_FALL = 8'd170;

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] supply = '0;
  logic [W-1:0] th_rise = TH_RISE;
  logic [W-1:0] th_fall = TH_FALL;
  logic         sleep = 1'b0, en = 1'b1, aux = 1'b0;
  logic         pgood, ref_en, err_en, run_en, aux_en, soft_dis;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  item_t q[$];

  // model state taken from the requirements
  bit           m_ok = 0;
  int           m_cnt = 0;
  logic [W-1:0] m_hi = '1;
  logic [W-1:0] m_lo = '0;

  always #2 clk = ~clk;

  supv_ctrl #(.W(W), .FILT_LEN(FILT_LEN)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .supply_i (supply),
    .th_rise_i (th_rise), .th_fall_i (th_fall),
    .sleep_i (sleep), .en_i (en), .aux_en_i (aux),
    .pgood_o (pgood), .ref_en_o (ref_en), .err_en_o (err_en),
    .run_en_o (run_en), .aux_en_o (aux_en), .soft_dis_o (soft_dis)
  );

  // output vector order: {pgood, ref_en, err_en, run_en, aux_en, soft_dis}
  function automatic logic [5:0] outs();
    return {pgood, ref_en, err_en, run_en, aux_en, soft_dis};
  endfunction

  task automatic step(input logic [W-1:0] s, input logic sl, input logic e,
                      input logic a, input string tag);
    item_t it;
    bit qual;
    @(negedge clk);
    supply = s; sleep = sl; en = e; aux = a;
    @(posedge clk);
    #0.5;
    // R10: outputs after this edge reflect state before it plus inputs at it
    it.exp = {m_ok & ~sl, ~sl, m_ok & ~sl, m_ok & ~sl & e, a & ~sl, sl | ~e | ~m_ok};
    it.tag = tag;
    q.push_back(it);
    qual = m_ok ? (s < m_lo) : (s >= m_hi);
    if (!qual) m_cnt = 0;
    else if (m_cnt == FILT_LEN - 1) begin m_ok = !m_ok; m_cnt = 0; end
    else m_cnt++;
    m_hi = th_rise; m_lo = th_fall;
  endtask

  task automatic run(input int n, input logic [W-1:0] s, input logic sl,
                     input logic e, input logic a, input string tag);
    for (int i = 0; i < n; i++) step(s, sl, e, a, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (outs() !== it.exp) begin
          errors++;
          $display("FAIL %s: outputs %b expected %b at %0t", it.tag, outs(), it.exp, $time);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outs() !== 6'b000001) begin
      errors++;
      $display("FAIL R1: reset outputs %b expected %b", outs(), 6'b000001);
    end
    rst_n = 1'b1;

    run(5, 8'd100, 0, 1, 0, "R5 locked out");
    run(1, 8'd100, 0, 0, 1, "R9 soft discharge while locked");
    run(2, 8'd210, 0, 1, 0, "R4 short rising run");
    run(2, 8'd150, 0, 1, 0, "R4 short run aborted");
    run(3, 8'd185, 0, 1, 0, "R4 in-band no rise");
    run(1, 8'd199, 0, 1, 0, "R2 one below rise threshold");
    run(3, 8'd200, 0, 1, 0, "R2 rise at threshold");
    run(4, 8'd200, 0, 1, 0, "R10 valid visible after latency");
    run(2, 8'd169, 0, 1, 0, "R4 short falling run");
    run(1, 8'd180, 0, 1, 0, "R4 falling run aborted");
    run(3, 8'd170, 0, 1, 0, "R3 at fall threshold holds");
    run(3, 8'd160, 0, 1, 0, "R3 fall below threshold");
    run(3, 8'd160, 0, 1, 1, "R5 lockout after fall");
    run(4, 8'd250, 0, 1, 0, "R2 recover");
    run(3, 8'd250, 0, 0, 0, "R7 enable low");
    run(2, 8'd250, 0, 0, 1, "R8 aux with enable low");
    run(2, 8'd250, 0, 1, 1, "R8 aux with enable high");
    run(3, 8'd250, 1, 1, 1, "R6 sleep overrides");
    run(2, 8'd250, 1, 0, 0, "R6 sleep with inputs low");
    run(2, 8'd250, 0, 1, 0, "R9 leave sleep");
    run(1, 8'd250, 0, 0, 0, "R9 enable drop");
    run(1, 8'd250, 0, 1, 1, "R10 one clock latency");
    run(2, 8'd250, 0, 1, 0, "R8 aux drop");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule